// File: doc/BRIEF.md
# Two-Wire Serial Memory Write Front End

This block is the bus-facing receiver of a serial non-volatile memory on a two-wire bus. It brings the clock and data lines into the system clock domain, finds Start and Stop conditions, and collects bytes most significant bit first. The first byte after a Start selects the device. The device answers only if that byte carries the fixed device-type code and the three select bits wired on its strap inputs. A write then takes a two-byte word address, followed by any number of data bytes. Each of these bytes is acknowledged by pulling the data line low during the ninth clock.

Each data byte is passed to a downstream write cache as a one-cycle strobe that carries the byte and its word address. A Stop after at least one data byte fires a commit pulse and starts a self-timed write interval. While that interval runs, the block refuses to acknowledge any control byte. The data line is open-drain: the block only ever requests a pull-low.

Top module: `eeprom_bus_frontend`

## Requirements
- R1: After reset, `sda_pull`, `busy`, `wr_stb` and `wr_start` are all low.
- R2: A control byte is acknowledged only when its bits [7:4] equal binary 1010 and its bits [3:1] equal `strap_sel`. Bytes arrive most significant bit first. A control byte that fails this match leaves `sda_pull` low, and later bytes are ignored until the next Start.
- R3: An acknowledge pull starts while SCL is low after the eighth bit. It is held through the high phase of the ninth clock and released after that clock's falling edge.
- R4: A matching control byte with bit 0 = 1 (read) is acknowledged. After it, the block is idle: later bytes are not acknowledged and no strobe or commit occurs.
- R5: For a write, the next byte supplies address bits [12:8] from its bits [4:0], and its bits [7:5] are ignored. The byte after that supplies address bits [7:0]. Both bytes are acknowledged.
- R6: Each data byte is acknowledged and produces a single-cycle `wr_stb`, with `wr_data` set to the byte and `wr_addr` set to its word address.
- R7: After each data byte, address bits [5:0] advance by one and wrap from 63 to 0. Bits [12:6] stay constant.
- R8: A Stop after at least one data byte gives a one-cycle `wr_start`, followed by `busy` high for exactly WRITE_CYCLES clocks. A Stop with no data byte gives no commit and no busy.
- R9: While `busy` is high, no control byte is acknowledged and no data strobe occurs.
- R10: A Start in the middle of a byte discards the partial byte and restarts control-byte reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level (wired-AND) |
| strap_sel | input | 3 | Device-select strap pins |
| sda_pull | output | 1 | Pull-low enable for the data line |
| busy | output | 1 | Internal write interval in progress |
| wr_stb | output | 1 | One-cycle data byte strobe |
| wr_addr | output | ADDR_W | Word address of the strobed byte |
| wr_data | output | 8 | Strobed data byte |
| wr_start | output | 1 | One-cycle commit pulse at Stop |

## Verification
The bench builds the block with WRITE_CYCLES = 400 and two synchroniser stages, with the straps tied to 3'b101. The write interval is short enough that the bench can send a full control byte while busy, see it refused, and still measure the whole interval. A starting address offset of 0x3E lets three data bytes cross the 64-byte wrap. A bus half-period of eight system clocks leaves margin for the synchroniser latency before each acknowledge sample.

// File: rtl/eeprom_fe_pkg.sv
// Package: shared types for the serial memory write front end.
// Assumes: nothing beyond IEEE 1800-2017.
package eeprom_fe_pkg;
    // Byte-level phase of the receiver
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_AHI,
        ST_ALO,
        ST_DATA
    } fe_state_t;
endpackage

// File: rtl/bus_line_sync.sv
// Module: bus_line_sync
// Brings SCL/SDA into the clk domain through STAGES flops and produces
// level, edge, Start and Stop indications (single-cycle pulses).
// Assumes: the bus is much slower than clk; STAGES >= 2.
module bus_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] scl_sh, sda_sh;
    logic          scl_q, sda_q;

    // Shift both lines through the synchroniser and keep one delayed copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[LAST-1:0], scl_in};
            sda_sh <= {sda_sh[LAST-1:0], sda_in};
            scl_q  <= scl_sh[LAST];
            sda_q  <= sda_sh[LAST];
        end
    end

    // Decode edges and bus conditions from current and delayed levels
    always_comb begin
        scl_lvl   = scl_sh[LAST];
        sda_lvl   = sda_sh[LAST];
        scl_rise  = scl_lvl & ~scl_q;
        scl_fall  = ~scl_lvl & scl_q;
        start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
        stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
    end
endmodule

// File: rtl/write_busy_timer.sv
// Module: write_busy_timer
// Holds busy high for exactly CYCLES clocks after a load pulse.
// Assumes: CYCLES >= 1; a load while busy restarts the interval.
module write_busy_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] CYC = CW'(CYCLES);

    logic [CW-1:0] cnt;

    // Load on commit, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= CYC;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/eeprom_bus_frontend.sv
// Module: eeprom_bus_frontend (top)
// Receives control, word address and data bytes from a two-wire bus,
// acknowledges matching transfers, strobes data bytes to a write cache
// and runs a self-timed write interval after Stop.
// Assumes: SCL half-period spans several clk cycles; reads are handled
// elsewhere; SDA is open-drain and driven only through sda_pull.
module eeprom_bus_frontend
    import eeprom_fe_pkg::*;
#(
    parameter int          SYNC_STAGES  = 2,
    parameter int          WRITE_CYCLES = 1000,
    parameter int          ADDR_W       = 13,
    parameter int          PAGE_W       = 6,
    parameter logic [3:0]  DEV_CODE     = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [2:0]        strap_sel,
    output logic              sda_pull,
    output logic              busy,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_start
);
    localparam int HI_W = ADDR_W - 8;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    fe_state_t         state, nxt, nxt_c;
    logic [7:0]        shreg;
    logic [3:0]        bit_cnt;
    logic              ack_ph, got_data, take;
    logic [ADDR_W-1:0] ptr;

    bus_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    write_busy_timer #(.CYCLES(WRITE_CYCLES)) timer_i (
        .clk(clk), .rst_n(rst_n), .load(wr_start), .busy(busy)
    );

    // Decide acknowledge and successor phase for a completed byte
    always_comb begin
        take  = 1'b0;
        nxt_c = ST_IDLE;
        case (state)
            ST_CTRL: begin
                take  = (shreg[7:4] == DEV_CODE) && (shreg[3:1] == strap_sel) && !busy;
                nxt_c = shreg[0] ? ST_IDLE : ST_AHI;
            end
            ST_AHI:  begin take = 1'b1; nxt_c = ST_ALO;  end
            ST_ALO:  begin take = 1'b1; nxt_c = ST_DATA; end
            ST_DATA: begin take = 1'b1; nxt_c = ST_DATA; end
            default: begin take = 1'b0; nxt_c = ST_IDLE; end
        endcase
    end

    // Byte reception, acknowledge drive, address pointer and strobes
    always_ff @(posedge clk) begin
        wr_stb   <= 1'b0;
        wr_start <= 1'b0;
        if (!rst_n) begin
            state    <= ST_IDLE;
            nxt      <= ST_IDLE;
            shreg    <= '0;
            bit_cnt  <= '0;
            ack_ph   <= 1'b0;
            sda_pull <= 1'b0;
            got_data <= 1'b0;
            ptr      <= '0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else if (start_det) begin
            state    <= ST_CTRL;
            bit_cnt  <= '0;
            ack_ph   <= 1'b0;
            sda_pull <= 1'b0;
            got_data <= 1'b0;
        end else if (stop_det) begin
            wr_start <= got_data && (state == ST_DATA);
            state    <= ST_IDLE;
            ack_ph   <= 1'b0;
            sda_pull <= 1'b0;
            got_data <= 1'b0;
        end else if (state != ST_IDLE) begin
            if (scl_rise && !ack_ph && bit_cnt != 4'd8) begin
                shreg   <= {shreg[6:0], sda_lvl};
                bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && ack_ph) begin
                sda_pull <= 1'b0;
                ack_ph   <= 1'b0;
                state    <= nxt;
            end else if (scl_fall && bit_cnt == 4'd8) begin
                bit_cnt <= '0;
                if (take) begin
                    sda_pull <= 1'b1;
                    ack_ph   <= 1'b1;
                    nxt      <= nxt_c;
                    case (state)
                        ST_AHI: ptr[ADDR_W-1:8] <= shreg[HI_W-1:0];
                        ST_ALO: ptr[7:0] <= shreg;
                        ST_DATA: begin
                            wr_stb               <= 1'b1;
                            wr_data              <= shreg;
                            wr_addr              <= ptr;
                            got_data             <= 1'b1;
                            ptr[PAGE_W-1:0]      <= ptr[PAGE_W-1:0] + 1'b1;
                        end
                        default: ;
                    endcase
                end else begin
                    state <= ST_IDLE;
                end
            end
        end
    end
endmodule

// File: rtl/eeprom_bus_frontend_chk.sv
// Module: eeprom_bus_frontend_chk
// Temporal checks on the front end, attached by bind.
// Assumes: clocked by the block's clk with its synchronous reset.
module eeprom_bus_frontend_chk (
    input logic clk,
    input logic rst_n,
    input logic sda_pull,
    input logic busy,
    input logic wr_stb,
    input logic wr_start,
    input logic scl_lvl
);
    p_no_ack_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !busy);

    p_no_stb_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_stb);

    p_stb_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    p_commit_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> busy);

    p_pull_on_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_lvl);
endmodule

bind eeprom_bus_frontend eeprom_bus_frontend_chk chk_i (
    .clk(clk), .rst_n(rst_n), .sda_pull(sda_pull), .busy(busy),
    .wr_stb(wr_stb), .wr_start(wr_start), .scl_lvl(scl_lvl)
);

// File: tb/eeprom_bus_frontend_tb_top.sv
// Directed bench for eeprom_bus_frontend: a bus master model plus one
// task per scenario, each checking its own results.
module eeprom_bus_frontend_tb_top;
    localparam int WRC  = 400;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1, m_sda = 1'b1;
    logic [2:0]  strap = 3'b101;
    logic        sda_pull, busy, wr_stb, wr_start;
    logic [12:0] wr_addr;
    logic [7:0]  wr_data;
    wire         sda_line = m_sda & ~sda_pull;

    int total = 0, bad = 0;
    int n_stb = 0, n_busy = 0, n_start = 0;
    logic [12:0] s_addr [0:15];
    logic [7:0]  s_data [0:15];

    always #10 clk = ~clk;

    eeprom_bus_frontend #(.WRITE_CYCLES(WRC)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
        .strap_sel(strap), .sda_pull(sda_pull), .busy(busy),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_start(wr_start)
    );

    // Record strobes and busy/commit activity seen at the ports
    always @(posedge clk) begin
        if (wr_stb) begin
            s_addr[n_stb % 16] <= wr_addr;
            s_data[n_stb % 16] <= wr_data;
            n_stb <= n_stb + 1;
        end
        if (busy) n_busy <= n_busy + 1;
        if (wr_start) n_start <= n_start + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wh(input int n); repeat (n) @(negedge clk); endtask

    task automatic b_start();
        m_sda = 1'b1; wh(HALF); m_scl = 1'b1; wh(HALF);
        m_sda = 1'b0; wh(HALF); m_scl = 1'b0; wh(HALF);
    endtask

    task automatic b_stop();
        m_sda = 1'b0; wh(HALF); m_scl = 1'b1; wh(HALF);
        m_sda = 1'b1; wh(HALF);
    endtask

    task automatic b_bit(input logic b);
        m_sda = b; wh(HALF); m_scl = 1'b1; wh(HALF); m_scl = 1'b0; wh(2);
    endtask

    task automatic b_byte(input logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) b_bit(v[i]);
        m_sda = 1'b1; wh(HALF); m_scl = 1'b1; wh(HALF/2);
        ack = ~sda_line;
        wh(HALF/2); m_scl = 1'b0; wh(2);
    endtask

    task automatic t_reset();
        chk("R1 sda_pull", sda_pull, 0);
        chk("R1 busy", busy, 0);
        chk("R1 strobes", n_stb + n_start, 0);
    endtask

    task automatic t_mismatch();
        logic a;
        b_start(); b_byte(8'hB0, a); chk("R2 wrong code ack", a, 0);
        b_start(); b_byte(8'hA4, a); chk("R2 wrong strap ack", a, 0);
        b_byte(8'h12, a); chk("R2 ignored byte ack", a, 0);
        b_stop();
        chk("R2 no strobe", n_stb, 0);
    endtask

    task automatic t_read();
        logic a;
        int s0 = n_stb, c0 = n_start;
        b_start(); b_byte(8'hAB, a); chk("R4 read ack", a, 1);
        wh(4); chk("R3 released after ninth", sda_pull, 0);
        b_byte(8'h55, a); chk("R4 idle after read", a, 0);
        b_stop(); wh(4);
        chk("R4 no strobe", n_stb - s0, 0);
        chk("R4 no commit", n_start - c0 + int'(busy), 0);
    endtask

    task automatic t_no_data();
        logic a;
        b_start(); b_byte(8'hAA, a); b_byte(8'h01, a); b_byte(8'h02, a);
        chk("R5 low addr ack", a, 1);
        b_stop(); wh(4);
        chk("R8 no busy without data", busy, 0);
    endtask

    task automatic t_page_write();
        logic a;
        int s0 = n_stb, b0;
        b_start(); b_byte(8'hAA, a); chk("R2 match ack", a, 1);
        b_byte(8'hE5, a); chk("R5 high addr ack", a, 1);
        b_byte(8'h3E, a); chk("R5 low addr ack", a, 1);
        b_byte(8'h11, a); chk("R6 data ack", a, 1);
        b_byte(8'h22, a); b_byte(8'h33, a);
        chk("R6 strobe count", n_stb - s0, 3);
        chk("R5 addr0", s_addr[s0 % 16], 13'h053E);
        chk("R6 data0", s_data[s0 % 16], 8'h11);
        chk("R7 addr1", s_addr[(s0+1) % 16], 13'h053F);
        chk("R7 wrap addr2", s_addr[(s0+2) % 16], 13'h0500);
        chk("R6 data2", s_data[(s0+2) % 16], 8'h33);
        b0 = n_busy;
        b_stop();
        chk("R8 busy after stop", busy, 1);
        b_start(); b_byte(8'hAA, a); chk("R9 nack while busy", a, 0);
        b_stop();
        chk("R9 still busy", busy, 1);
        while (busy) @(negedge clk);
        chk("R8 busy length", n_busy - b0, WRC);
    endtask

    task automatic t_restart();
        logic a;
        int s0 = n_stb;
        b_start(); b_bit(1'b1); b_bit(1'b0); b_bit(1'b1); b_bit(1'b0);
        b_start(); b_byte(8'hAA, a); chk("R10 ack after restart", a, 1);
        b_byte(8'h00, a); b_byte(8'h10, a); b_byte(8'h77, a);
        b_stop();
        chk("R10 strobe addr", s_addr[s0 % 16], 13'h0010);
        chk("R10 strobe data", s_data[s0 % 16], 8'h77);
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wh(5); rst_n = 1'b1; wh(5);
        t_reset();
        t_mismatch();
        t_read();
        t_no_data();
        t_page_write();
        t_restart();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule